// File: doc/BRIEF.md
# Freezable event counter bank

This block is a memory-mapped bank of performance counters. Counter 0 counts every clock cycle and is 64 bits wide. Counters 1 to 10 are 32 bits wide. Each of them counts one bit of an event input vector, and a 7-bit select field in the counter's own control register picks that bit. Software reaches the bank through a plain write strobe, address and data port. Reads are combinational from the address.

Counting is gated by two levels of freeze. A global freeze-all bit overrides everything. Below it, each counter has its own freeze bit. A counter can also be armed to watch its most significant bit. When an increment carries that bit from 0 to 1 while arming is complete, the hardware sets the global freeze-all bit at the same clock edge, so every count is captured at that instant. A level interrupt also rises. Software clears the counter's top bit by writing the counter and then releases the freeze by writing the global register.

Top module: `evtmon_bank`

## Requirements
- R1: After the synchronous active-high reset, every counter value and every local control register reads 0. The global register reads 0x8000_0000 (freeze-all set, both enables clear), and irq_o is low.
- R2: Register map, with all other bits reading 0:
  - Global register at 0x40: bit 31 is freeze-all, bit 30 is interrupt enable, and bit 29 enables freeze on an overflow condition.
  - Local control register of counter n at 0x50+0x10*n: bit 31 is the local freeze, bit 26 is the condition enable, and bits 22:16 are the event select.
  - Value of counter n at 0x58+0x10*n. The upper half of counter 0 is at 0x5C.
  - Every other address reads 0, and a write to it changes nothing.
- R3: Counter 0 increments by one on every clock edge at which it is not frozen. Its select field is stored but has no effect, and it carries from the low word into the upper word.
- R4: Counter n (n from 1 to 10) increments by one on an edge where evt_in[select] is 1 and it is not frozen. It wraps at 32 bits. A select value of 64 or more (past the event vector) never increments it.
- R5: A counter holds its value while the global freeze-all bit or its own freeze bit is set. The global bit wins, whatever the local bit says.
- R6: A write to a counter's value register takes priority over an increment in the same cycle. The written value is read back on the next cycle. The two halves of counter 0 are written independently.
- R7: Suppose interrupt enable, freeze-on-condition and the counter's condition enable are all 1. If an increment then carries a counter's most significant bit (bit 31, or bit 63 for counter 0) from 0 to 1, freeze-all is set at that same edge and no counter advances afterwards.
- R8: If any one of those three enables is 0, an MSB carry leaves freeze-all unchanged and counting continues.
- R9: irq_o is high exactly when interrupt enable and freeze-on-condition are both 1 and some counter with its condition enable set has its MSB at 1. It drops once software writes that MSB to 0.
- R10: If an overflow carry and a software write to the global register happen in the same cycle, the freeze-all bit set by hardware wins over the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the cycle source for counter 0 |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 12 | Byte address for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_in | input | 64 | Event vector, one bit per event source |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
Several counters are pointed at the same event bit and at different bits. The event vector then takes walking-one, alternating and all-ones patterns. This separates a counter that follows its own select from one that follows a neighbour's. Counters given select values of 64 and 127 under an all-ones vector show whether an out-of-range index is masked or wraps into the vector.

Counters are preloaded just below their MSB under each combination of the three enables. These runs tell a freeze raised by the carry apart from one raised by a bare MSB value, and they show which enable gates it. One overflow is made to collide with a global register write in the same cycle.

The register port is read from a rotating list of every address on each idle clock. This exposes a freeze that is late by one cycle, or a write that loses to an increment.

// File: rtl/evtmon_pkg.sv
package evtmon_pkg;

    // bus geometry
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 12;
    localparam int SEL_W    = 7;

    // default bank shape
    localparam int NUM_CNT_D = 11;
    localparam int EVT_W_D   = 64;
    localparam int EV_CW_D   = 32;
    localparam int CY_CW_D   = 64;

    // address layout
    localparam int GLB_OFS  = 'h40;
    localparam int LCTL_OFS = 'h50;
    localparam int VAL_OFS  = 'h58;
    localparam int STRIDE   = 'h10;
    localparam int HI_OFS   = 'h4;

    // field positions
    localparam int G_FRZ_B  = 31;
    localparam int G_IE_B   = 30;
    localparam int G_FCE_B  = 29;
    localparam int L_FRZ_B  = 31;
    localparam int L_CE_B   = 26;
    localparam int L_SEL_LO = 16;

    typedef struct packed {
        logic frz_all;
        logic irq_en;
        logic fce;
    } gctl_t;

    typedef struct packed {
        logic             frz;
        logic             ce;
        logic [SEL_W-1:0] sel;
    } lctl_t;

    function automatic logic [ADDR_W-1:0] glb_addr();
        return ADDR_W'(GLB_OFS);
    endfunction

    function automatic logic [ADDR_W-1:0] lctl_addr(input int n);
        return ADDR_W'(LCTL_OFS + n * STRIDE);
    endfunction

    function automatic logic [ADDR_W-1:0] val_addr(input int n);
        return ADDR_W'(VAL_OFS + n * STRIDE);
    endfunction

    function automatic logic [DATA_W-1:0] gctl_pack(input gctl_t g);
        logic [DATA_W-1:0] w;
        w = '0;
        w[G_FRZ_B] = g.frz_all;
        w[G_IE_B]  = g.irq_en;
        w[G_FCE_B] = g.fce;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] lctl_pack(input lctl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[L_FRZ_B] = c.frz;
        w[L_CE_B]  = c.ce;
        w[L_SEL_LO +: SEL_W] = c.sel;
        return w;
    endfunction

endpackage

// File: rtl/evtmon_slice.sv
module evtmon_slice
    import evtmon_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          gfrz,
    input  logic          hit,
    input  logic          wr_ctl,
    input  lctl_t         ctl_w,
    input  logic          wr_cnt,
    input  logic [CW-1:0] cnt_w,
    output lctl_t         ctl,
    output logic [CW-1:0] cnt,
    output logic          adv,
    output logic          rise,
    output logic          msb
);

    logic [CW-1:0] inc;

    assign inc  = cnt + CW'(1);
    assign adv  = hit && !gfrz && !ctl.frz;
    assign rise = adv && !wr_cnt && !cnt[CW-1] && inc[CW-1];
    assign msb  = cnt[CW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
            cnt <= '0;
        end else begin
            if (wr_ctl) ctl <= ctl_w;
            if (wr_cnt)   cnt <= cnt_w;
            else if (adv) cnt <= inc;
        end
    end

    // frozen counters hold unless software writes them
    assert_hold_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        ((gfrz || ctl.frz) && !wr_cnt) |=> $stable(cnt));

    // an enabled, unwritten counter steps by exactly one
    assert_step_one_R4: assert property (@(posedge clk) disable iff (rst)
        (adv && !wr_cnt) |=> (cnt == $past(cnt) + CW'(1)));

    // software write wins over the increment
    assert_write_wins_R6: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> (cnt == $past(cnt_w)));

endmodule

// File: rtl/evtmon_glob.sv
module evtmon_glob
    import evtmon_pkg::*;
#(
    parameter int NCNT = NUM_CNT_D
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  gctl_t           g_w,
    input  logic [NCNT-1:0] rise,
    input  logic [NCNT-1:0] msb,
    input  logic [NCNT-1:0] ce,
    output gctl_t           g,
    output logic            irq
);

    logic  armed;
    logic  trig;
    gctl_t g_nxt;

    assign armed = g.irq_en && g.fce;
    assign trig  = armed && |(rise & ce);
    assign irq   = armed && |(msb & ce);

    always_comb begin
        g_nxt = wr ? g_w : g;
        if (trig) g_nxt.frz_all = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            g <= '{frz_all: 1'b1, irq_en: 1'b0, fce: 1'b0};
        end else begin
            g <= g_nxt;
        end
    end

    // a qualified carry freezes everything at that edge (also over a write, R10)
    assert_trig_freeze_R7: assert property (@(posedge clk) disable iff (rst)
        trig |=> g.frz_all);

    // without both global enables and without a write the register never moves
    assert_no_auto_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        (!armed && !wr) |=> $stable(g));

    // the interrupt never shows while the global gates are off
    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
        !(g.irq_en && g.fce) |-> !irq);

endmodule

// File: rtl/evtmon_bank.sv
module evtmon_bank
    import evtmon_pkg::*;
#(
    parameter int NCNT  = NUM_CNT_D,
    parameter int EVT_W = EVT_W_D,
    parameter int EV_CW = EV_CW_D,
    parameter int CY_CW = CY_CW_D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [EVT_W-1:0]  evt_in,
    output logic              irq_o
);

    localparam int CY_HI_W = CY_CW - DATA_W;
    localparam int EIDX_W  = $clog2(EVT_W);

    gctl_t             gctl;
    gctl_t             gctl_w;
    lctl_t             ctl_w;
    lctl_t             ctl [NCNT];
    logic [NCNT-1:0]   adv;
    logic [NCNT-1:0]   rise;
    logic [NCNT-1:0]   msb;
    logic [NCNT-1:0]   ce;
    logic [CY_CW-1:0]  cyc_cnt;
    logic [EV_CW-1:0]  ev_cnt [1:NCNT-1];
    logic              wr_glb;

    assign wr_glb = bus_wr && (bus_addr == glb_addr());
    assign gctl_w = '{frz_all: bus_wdata[G_FRZ_B],
                      irq_en:  bus_wdata[G_IE_B],
                      fce:     bus_wdata[G_FCE_B]};
    assign ctl_w  = '{frz: bus_wdata[L_FRZ_B],
                      ce:  bus_wdata[L_CE_B],
                      sel: bus_wdata[L_SEL_LO +: SEL_W]};

    for (genvar n = 0; n < NCNT; n++) begin : g_cnt
        logic wr_ctl;
        assign wr_ctl = bus_wr && (bus_addr == lctl_addr(n));
        assign ce[n]  = ctl[n].ce;

        if (n == 0) begin : g_cycle
            logic             wr_lo;
            logic             wr_hi;
            logic [CY_CW-1:0] wval;
            assign wr_lo = bus_wr && (bus_addr == val_addr(0));
            assign wr_hi = bus_wr && (bus_addr == val_addr(0) + ADDR_W'(HI_OFS));
            assign wval  = wr_hi ? {bus_wdata[CY_HI_W-1:0], cyc_cnt[DATA_W-1:0]}
                                 : {cyc_cnt[CY_CW-1:DATA_W], bus_wdata};
            evtmon_slice #(.CW(CY_CW)) u_slice (
                .clk    (clk),
                .rst    (rst),
                .gfrz   (gctl.frz_all),
                .hit    (1'b1),
                .wr_ctl (wr_ctl),
                .ctl_w  (ctl_w),
                .wr_cnt (wr_lo || wr_hi),
                .cnt_w  (wval),
                .ctl    (ctl[n]),
                .cnt    (cyc_cnt),
                .adv    (adv[n]),
                .rise   (rise[n]),
                .msb    (msb[n])
            );
        end else begin : g_event
            logic             wr_v;
            logic             hit;
            logic [EV_CW-1:0] cnt_o;
            assign wr_v = bus_wr && (bus_addr == val_addr(n));
            assign hit  = (32'(ctl[n].sel) < EVT_W) && evt_in[ctl[n].sel[EIDX_W-1:0]];
            evtmon_slice #(.CW(EV_CW)) u_slice (
                .clk    (clk),
                .rst    (rst),
                .gfrz   (gctl.frz_all),
                .hit    (hit),
                .wr_ctl (wr_ctl),
                .ctl_w  (ctl_w),
                .wr_cnt (wr_v),
                .cnt_w  (bus_wdata[EV_CW-1:0]),
                .ctl    (ctl[n]),
                .cnt    (cnt_o),
                .adv    (adv[n]),
                .rise   (rise[n]),
                .msb    (msb[n])
            );
            assign ev_cnt[n] = cnt_o;

            // an out-of-range select never lets the counter advance
            assert_sel_range_R4: assert property (@(posedge clk) disable iff (rst)
                (32'(ctl[n].sel) >= EVT_W) |-> !adv[n]);
        end
    end

    evtmon_glob #(.NCNT(NCNT)) u_glob (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr_glb),
        .g_w  (gctl_w),
        .rise (rise),
        .msb  (msb),
        .ce   (ce),
        .g    (gctl),
        .irq  (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == glb_addr()) bus_rdata = gctl_pack(gctl);
        for (int n = 0; n < NCNT; n++) begin
            if (bus_addr == lctl_addr(n)) bus_rdata = lctl_pack(ctl[n]);
        end
        if (bus_addr == val_addr(0)) bus_rdata = cyc_cnt[DATA_W-1:0];
        if (bus_addr == val_addr(0) + ADDR_W'(HI_OFS))
            bus_rdata = DATA_W'(cyc_cnt[CY_CW-1:DATA_W]);
        for (int n = 1; n < NCNT; n++) begin
            if (bus_addr == val_addr(n)) bus_rdata = DATA_W'(ev_cnt[n]);
        end
    end

    // global freeze stops every counter regardless of local state
    assert_global_priority_R5: assert property (@(posedge clk) disable iff (rst)
        gctl.frz_all |-> (adv == '0));

endmodule

// File: tb/evtmon_bank_tb_top.sv
module evtmon_bank_tb_top;

    localparam int NC = 11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] evt_in = '0;
    logic        irq_o;

    int    vectors = 0;
    int    fails   = 0;
    int    rot     = 0;
    string cur_req = "R1";

    // reference model state
    longint unsigned m_cnt [NC];
    bit              m_frz [NC];
    bit              m_ce  [NC];
    int              m_sel [NC];
    bit              g_frz, g_ie, g_fce;

    evtmon_bank dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_in    (evt_in),
        .irq_o     (irq_o)
    );

    always #5 clk = ~clk;

    function automatic bit top_bit(int n, longint unsigned v);
        return (n == 0) ? v[63] : v[31];
    endfunction

    function automatic void model_reset();
        for (int n = 0; n < NC; n++) begin
            m_cnt[n] = 0; m_frz[n] = 0; m_ce[n] = 0; m_sel[n] = 0;
        end
        g_frz = 1; g_ie = 0; g_fce = 0;
    endfunction

    function automatic logic [31:0] model_read(logic [11:0] a);
        if (a == 12'h040) return {g_frz, g_ie, g_fce, 29'b0};
        if (a == 12'h05C) return m_cnt[0][63:32];
        for (int n = 0; n < NC; n++) begin
            if (a == 12'(32'h50 + 16 * n))
                return {m_frz[n], 4'b0, m_ce[n], 3'b0, 7'(m_sel[n]), 16'b0};
            if (a == 12'(32'h58 + 16 * n)) return m_cnt[n][31:0];
        end
        return 32'h0;
    endfunction

    function automatic bit model_irq();
        bit any = 0;
        for (int n = 0; n < NC; n++) if (m_ce[n] && top_bit(n, m_cnt[n])) any = 1;
        return g_ie && g_fce && any;
    endfunction

    function automatic void model_step(bit we, logic [11:0] a, logic [31:0] d, logic [63:0] e);
        bit armed = g_ie && g_fce;
        bit carry = 0;
        for (int n = 0; n < NC; n++) begin
            longint unsigned old = m_cnt[n];
            longint unsigned nw  = old;
            bit wrc = 0;
            bit adv = !g_frz && !m_frz[n] && (n == 0 || (m_sel[n] < 64 && e[m_sel[n]]));
            if (we && a == 12'(32'h58 + 16 * n)) begin
                nw  = (n == 0) ? {old[63:32], d} : {32'h0, d};
                wrc = 1;
            end
            if (we && n == 0 && a == 12'h05C) begin
                nw  = {d, old[31:0]};
                wrc = 1;
            end
            if (!wrc && adv) begin
                nw = old + 1;
                if (n != 0) nw = nw & 64'hFFFF_FFFF;
                if (!top_bit(n, old) && top_bit(n, nw) && m_ce[n]) carry = 1;
            end
            m_cnt[n] = nw;
        end
        for (int n = 0; n < NC; n++) begin
            if (we && a == 12'(32'h50 + 16 * n)) begin
                m_frz[n] = d[31]; m_ce[n] = d[26]; m_sel[n] = int'(d[22:16]);
            end
        end
        if (we && a == 12'h040) begin
            g_frz = d[31]; g_ie = d[30]; g_fce = d[29];
        end
        if (armed && carry) g_frz = 1;
    endfunction

    function automatic logic [11:0] rot_addr(int k);
        if (k == 0)  return 12'h040;
        if (k <= 11) return 12'(32'h50 + 16 * (k - 1));
        if (k <= 22) return 12'(32'h58 + 16 * (k - 12));
        if (k == 23) return 12'h05C;
        return 12'h000;
    endfunction

    // called just after a falling edge; returns just after the next one
    task automatic cyc(input bit we, input logic [11:0] a, input logic [31:0] d, input logic [63:0] e);
        logic [31:0] exp_rd;
        bit          exp_irq;
        bus_wr = we; bus_addr = a; bus_wdata = d; evt_in = e;
        #1;
        exp_rd  = model_read(a);
        exp_irq = model_irq();
        vectors++;
        if (bus_rdata !== exp_rd) begin
            fails++;
            $display("FAIL %s rdata @%h actual %h expected %h", cur_req, a, bus_rdata, exp_rd);
        end
        vectors++;
        if (irq_o !== exp_irq) begin
            fails++;
            $display("FAIL %s irq_o actual %b expected %b", cur_req, irq_o, exp_irq);
        end
        @(posedge clk);
        model_step(we, a, d, e);
        @(negedge clk);
    endtask

    task automatic idle(input int cycles, input logic [63:0] e);
        for (int i = 0; i < cycles; i++) begin
            cyc(1'b0, rot_addr(rot % 25), 32'h0, e);
            rot++;
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [63:0] e);
        cyc(1'b1, a, d, e);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired during %s", cur_req);
        summary();
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values, all frozen
        cur_req = "R1";
        idle(30, '1);

        // R2: field masking and unmapped addresses
        cur_req = "R2";
        wr(12'h040, 32'hFFFF_FFFF, '0);
        wr(12'h080, 32'hFFFF_FFFF, '0);
        wr(12'h000, 32'hDEAD_BEEF, '0);
        wr(12'h044, 32'hDEAD_BEEF, '0);
        wr(12'h054, 32'hDEAD_BEEF, '0);
        wr(12'h0AC, 32'hDEAD_BEEF, '0);
        idle(26, '0);
        wr(12'h080, 32'h0, '0);
        wr(12'h040, 32'h0, '0);

        // R3: cycle counter, select ignored
        cur_req = "R3";
        wr(12'h050, 32'h0005_0000, '0);
        for (int i = 0; i < 12; i++) cyc(1'b0, 12'h058, 32'h0, '0);

        // R4: event select under several patterns
        cur_req = "R4";
        wr(12'h060, 32'h0000_0000, '0);
        wr(12'h070, 32'h0005_0000, '0);
        wr(12'h080, 32'h0005_0000, '0);
        wr(12'h090, 32'h003F_0000, '0);
        wr(12'h0A0, 32'h0040_0000, '0);
        wr(12'h0B0, 32'h007F_0000, '0);
        for (int i = 0; i < 64; i++) cyc(1'b0, rot_addr(12 + (i % 7)), 32'h0, 64'h1 << i);
        for (int i = 0; i < 20; i++)
            cyc(1'b0, rot_addr(12 + (i % 7)), 32'h0, (i % 2) ? 64'hAAAA_AAAA_AAAA_AAAA : 64'h5555_5555_5555_5555);
        idle(30, '1);

        // R5: local freeze then global over local
        cur_req = "R5";
        wr(12'h080, 32'h8005_0000, '1);
        for (int i = 0; i < 8; i++) cyc(1'b0, (i % 2) ? 12'h088 : 12'h078, 32'h0, '1);
        wr(12'h040, 32'h8000_0000, '1);
        idle(26, '1);
        wr(12'h040, 32'h0, '1);
        wr(12'h080, 32'h0005_0000, '1);
        idle(10, '1);

        // R6: write beats increment; halves of the cycle counter
        cur_req = "R6";
        wr(12'h078, 32'h0000_1234, '1);
        cyc(1'b0, 12'h078, 32'h0, '1);
        wr(12'h05C, 32'h0000_00AB, '0);
        wr(12'h058, 32'hFFFF_FFF0, '0);
        for (int i = 0; i < 24; i++) cyc(1'b0, (i % 2) ? 12'h05C : 12'h058, 32'h0, '0);

        // R7: armed overflow freezes the bank
        cur_req = "R7";
        wr(12'h0B0, 32'h0401_0000, '0);
        wr(12'h0B8, 32'h7FFF_FFFD, '0);
        wr(12'h040, 32'h6000_0000, '0);
        for (int i = 0; i < 6; i++) cyc(1'b0, (i % 2) ? 12'h040 : 12'h0B8, 32'h0, 64'h2);
        idle(26, '1);

        // R9: clearing the MSB drops the level, then release
        cur_req = "R9";
        cyc(1'b0, 12'h0B8, 32'h0, '0);
        wr(12'h0B8, 32'h0, '0);
        cyc(1'b0, 12'h0B8, 32'h0, '0);
        wr(12'h040, 32'h6000_0000, '0);
        idle(10, 64'h2);

        // R8: carries that must not freeze
        cur_req = "R8";
        wr(12'h0C0, 32'h0002_0000, '0);
        wr(12'h0C8, 32'h7FFF_FFFF, '0);
        for (int i = 0; i < 4; i++) cyc(1'b0, (i % 2) ? 12'h040 : 12'h0C8, 32'h0, 64'h4);
        wr(12'h040, 32'h4000_0000, '0);
        wr(12'h0D0, 32'h0403_0000, '0);
        wr(12'h0D8, 32'h7FFF_FFFF, '0);
        for (int i = 0; i < 4; i++) cyc(1'b0, (i % 2) ? 12'h040 : 12'h0D8, 32'h0, 64'h8);
        wr(12'h040, 32'h2000_0000, '0);
        wr(12'h0D8, 32'h7FFF_FFFF, '0);
        for (int i = 0; i < 4; i++) cyc(1'b0, (i % 2) ? 12'h040 : 12'h0D8, 32'h0, 64'h8);
        wr(12'h0D8, 32'h0, '0);
        idle(25, '0);

        // R10: overflow collides with a global write
        cur_req = "R10";
        wr(12'h040, 32'h8000_0000, '0);
        wr(12'h0B8, 32'h7FFF_FFFF, '0);
        wr(12'h040, 32'h6000_0000, '0);
        wr(12'h040, 32'h6000_0000, 64'h2);
        idle(26, 64'h2);
        wr(12'h0B8, 32'h0, '0);

        // R7 on the 64-bit cycle counter
        cur_req = "R7";
        wr(12'h040, 32'hE000_0000, '0);
        wr(12'h05C, 32'h7FFF_FFFF, '0);
        wr(12'h058, 32'hFFFF_FFFE, '0);
        wr(12'h050, 32'h0400_0000, '0);
        wr(12'h040, 32'h6000_0000, '0);
        for (int i = 0; i < 6; i++) cyc(1'b0, (i % 2) ? 12'h05C : 12'h058, 32'h0, '0);
        idle(25, '1);
        cur_req = "R9";
        wr(12'h05C, 32'h0, '0);
        idle(25, '1);

        summary();
        $finish;
    end

endmodule